// File: doc/BRIEF.md
# IO Window Access Decoder with Bus-Error Filter

This block decodes processor accesses into the top 32 KiB of a 24-bit address space, the window from 0xFF8000 to 0xFFFFFF, on a bus with 16-bit data. Each request carries an address, an access size of byte, word or long, a read/write flag, a supervisor flag and write data. The block looks at every byte the access covers and puts each one in one of three classes: a mapped register, a void location that accepts and ignores accesses, or a hole that raises a bus error. It then returns one registered response with the assembled read data and a single-cycle bus-error strobe.

A bus error is raised only when every byte of the access lands in a hole. A word access that touches one real register therefore completes, even though a byte access to the hole half faults. A machine-variant input selects among four decode maps. The maps differ in which holes are void, whether the blitter and clock ranges respond, and whether the sound-chip registers are mirrored across their page. The registers behind the decoder are a plain byte store.

Top module: `io_win_decoder`

## Requirements
- R1: Address bits 31..24 are ignored. A request whose 24-bit address is below 0xFF8000, or that is made with `req_super` low, faults whatever the map says.
- R2: A window byte that no map rule covers is a hole, so a byte access to it faults.
- R3: The block counts the holes among the bytes an access covers (1 for `req_size`=0 byte, 2 for 1 word, 4 for 2 long). It faults only when that count equals the access size. Writes to mapped lanes of a non-faulting access are committed even when other lanes are holes.
- R4: On a non-faulting read, a hole lane and a void lane return 0xFF. In the base map (`mode`=0), 0xFF820F and 0xFF860F are void and read 0x00. In every other map they are holes. Writes to void bytes change nothing.
- R5: A word access at 0xFFFFFF, a long access above 0xFFFFFC, and size code 3 are always rejected with a fault.
- R6: In `mode` 0, 1 and 2, addresses 0xFF8804 to 0xFF88FF alias the sound registers at 0xFF8800 to 0xFF8803, found by ANDing the address with 0xFFF803. In `mode`=3 there is no aliasing: that range is void when `compat` is 1 and a hole when `compat` is 0.
- R7: In the extended map (`mode`=1), these bytes are void: 0xFF8000, 0xFF8002 to 0xFF800D, the even addresses 0xFF8200 to 0xFF8208, 0xFF820C, 0xFF8608, 0xFF860A and 0xFF860C.
- R8: 0xFF8A00 to 0xFF8A3F is a register range, except that in `mode`=0 with `blit_off` high it is a hole.
- R9: 0xFFFC21 to 0xFFFC3F is a register range in `mode` 1 and 3 and void in `mode` 0 and 2.
- R10: On a fault, nothing is written, `rsp_rdata` is all ones, and `rsp_berr` is high for exactly the one cycle in which `rsp_valid` is high.
- R11: Lanes are big-endian: the byte at the lowest address sits in the most significant used byte. Byte results use bits 7..0, word results use 15..0, long results use 31..0, and the unused upper bits are zero. A write response returns zero data. Write data uses the same lane placement.
- R12: The response appears one clock after the request. After synchronous reset, `rsp_valid`, `rsp_berr` and `rsp_rdata` are zero, and every register byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Byte address; only bits 23..0 are used |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 rejected |
| req_write | input | 1 | 1 write, 0 read |
| req_super | input | 1 | Supervisor-state access |
| req_wdata | input | 32 | Write data, right-aligned big-endian |
| mode | input | 2 | Decode map: 0 base, 1 extended, 2 enhanced, 3 newest |
| compat | input | 1 | Compatibility sub-mode of the newest map |
| blit_off | input | 1 | Remove the blitter range in the base map |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data, all ones on fault |
| rsp_berr | output | 1 | Bus-error strobe |

## Verification
The bench targets the partial-fault case: a word that straddles a hole and a register must complete, with 0xFF in the hole lane and the write reaching only the register. A design that faults on any hole would return all ones and drop the write. The bench also reaches the sound page through its mirror, in the aliasing maps and in the non-aliasing map. A wrong mask or mode test shows up there as a stale value, as a fault, or as 0xFF in place of stored data. Finally, the bench checks the void-reads-zero pair, the per-map void lists, the top-of-window rejection, and a rejected write followed by a read-back. A decoder that commits before deciding to fault would change the stored register.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
  localparam int ADDR_W = 24;
  localparam int LANES  = 4;
  localparam int IDX_W  = 8;
  localparam int DEPTH  = 1 << IDX_W;

  localparam logic [ADDR_W-1:0] WIN_BASE = 24'hFF8000;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_BAD = 2'd3} size_e;
  typedef enum logic [1:0] {MD_BASE = 2'd0, MD_EXT = 2'd1, MD_ENH = 2'd2, MD_NEW = 2'd3} mode_e;
  typedef enum logic [1:0] {CL_HOLE = 2'd0, CL_VOID_FF = 2'd1, CL_VOID_00 = 2'd2, CL_REG = 2'd3} lane_cls_e;
endpackage

// File: rtl/io_win_lane_dec.sv
module io_win_lane_dec
  import io_win_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        mode,
  input  logic              compat,
  input  logic              blit_off,
  output lane_cls_e         cls,
  output logic [IDX_W-1:0]  idx
);
  logic              in_mirror;
  logic [ADDR_W-1:0] a;
  logic              ext_void;

  // sound page mirror: only maps without the newest bus
  assign in_mirror = (addr >= 24'hFF8804) && (addr <= 24'hFF88FF);
  assign a = (in_mirror && mode != MD_NEW) ? (addr & 24'hFFF803) : addr;

  always_comb begin
    ext_void = 1'b0;
    case (a)
      24'hFF8000, 24'hFF8200, 24'hFF8202, 24'hFF8204, 24'hFF8206,
      24'hFF8208, 24'hFF820C, 24'hFF8608, 24'hFF860A, 24'hFF860C: ext_void = 1'b1;
      default: ext_void = (a >= 24'hFF8002) && (a <= 24'hFF800D);
    endcase
  end

  always_comb begin
    cls = CL_HOLE;
    idx = '0;
    if (in_mirror && mode == MD_NEW) begin
      cls = compat ? CL_VOID_FF : CL_HOLE;
    end else if (a >= 24'hFF8800 && a <= 24'hFF8803) begin
      cls = CL_REG;
      idx = IDX_W'({6'd0, a[1:0]});
    end else if (a == 24'hFF8201 || a == 24'hFF8203) begin
      cls = CL_REG;
      idx = IDX_W'(4 + a[1]);
    end else if (a >= 24'hFF8A00 && a <= 24'hFF8A3F) begin
      cls = (mode == MD_BASE && blit_off) ? CL_HOLE : CL_REG;
      idx = IDX_W'({2'b01, a[5:0]});
    end else if (a >= 24'hFFFC21 && a <= 24'hFFFC3F) begin
      cls = (mode == MD_EXT || mode == MD_NEW) ? CL_REG : CL_VOID_FF;
      idx = IDX_W'({2'b10, a[5:0]});
    end else if (mode == MD_BASE && (a == 24'hFF820F || a == 24'hFF860F)) begin
      cls = CL_VOID_00;
    end else if (mode == MD_EXT && ext_void) begin
      cls = CL_VOID_FF;
    end
  end
endmodule

// File: rtl/io_win_regfile.sv
module io_win_regfile
  import io_win_pkg::*;
#(
  parameter int NLANE = LANES,
  parameter int NDEEP = DEPTH
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NLANE-1:0]            we,
  input  logic [NLANE-1:0][IDX_W-1:0] idx,
  input  logic [NLANE-1:0][7:0]       wdat,
  output logic [NLANE-1:0][7:0]       rdat
);
  logic [7:0] mem [NDEEP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NDEEP; k++) mem[k] <= 8'h00;
    end else begin
      for (int l = 0; l < NLANE; l++)
        if (we[l]) mem[idx[l]] <= wdat[l];
    end
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_rd
    assign rdat[g] = mem[idx[g]];
  end
endmodule

// File: rtl/io_win_decoder.sv
module io_win_decoder
  import io_win_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic        req_write,
  input  logic        req_super,
  input  logic [31:0] req_wdata,
  input  logic [1:0]  mode,
  input  logic        compat,
  input  logic        blit_off,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        rsp_berr
);
  logic [ADDR_W-1:0]           addr24;
  logic [7:0]                  unused_hi;
  lane_cls_e                   cls [LANES];
  logic [LANES-1:0][IDX_W-1:0] lidx;
  logic [LANES-1:0][7:0]       lrd, lwd, lval;
  logic [LANES-1:0]            active, hole, lwe;
  int                          nbytes;
  logic                        reject, fault;
  logic [31:0]                 rd_asm;

  assign addr24    = req_addr[ADDR_W-1:0];
  assign unused_hi = req_addr[31:24];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    io_win_lane_dec u_dec (
      .addr    (addr24 + ADDR_W'(g)),
      .mode    (mode),
      .compat  (compat),
      .blit_off(blit_off),
      .cls     (cls[g]),
      .idx     (lidx[g])
    );
    assign active[g] = (g < nbytes);
    assign hole[g]   = active[g] && (cls[g] == CL_HOLE);
    assign lwe[g]    = req_valid && req_write && !fault && active[g] && (cls[g] == CL_REG);
    assign lval[g]   = (cls[g] == CL_REG) ? lrd[g] : (cls[g] == CL_VOID_00) ? 8'h00 : 8'hFF;
  end

  always_comb begin
    case (req_size)
      SZ_BYTE: nbytes = 1;
      SZ_WORD: nbytes = 2;
      default: nbytes = 4;
    endcase
  end

  always_comb begin
    reject = (addr24 < WIN_BASE) || !req_super || (req_size == SZ_BAD)
          || (req_size == SZ_WORD && addr24 > 24'hFFFFFE)
          || (req_size == SZ_LONG && addr24 > 24'hFFFFFC);
    fault  = reject || ($countones(hole) == nbytes);
  end

  // big-endian lane placement, right-aligned
  always_comb begin
    lwd = '0;
    case (req_size)
      SZ_BYTE: begin
        rd_asm = {24'h0, lval[0]};
        lwd[0] = req_wdata[7:0];
      end
      SZ_WORD: begin
        rd_asm = {16'h0, lval[0], lval[1]};
        lwd[0] = req_wdata[15:8];
        lwd[1] = req_wdata[7:0];
      end
      default: begin
        rd_asm = {lval[0], lval[1], lval[2], lval[3]};
        lwd[0] = req_wdata[31:24];
        lwd[1] = req_wdata[23:16];
        lwd[2] = req_wdata[15:8];
        lwd[3] = req_wdata[7:0];
      end
    endcase
  end

  io_win_regfile u_regs (
    .clk (clk),
    .rst (rst),
    .we  (lwe),
    .idx (lidx),
    .wdat(lwd),
    .rdat(lrd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_berr  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_berr  <= req_valid && fault;
      if (!req_valid || (req_write && !fault)) rsp_rdata <= '0;
      else if (fault)                          rsp_rdata <= '1;
      else                                     rsp_rdata <= rd_asm;
    end
  end

  assert_berr_with_valid_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_berr |-> rsp_valid);
  assert_fault_all_ones_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_berr |-> (rsp_rdata == 32'hFFFF_FFFF));
  assert_user_state_fault_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_super) |=> rsp_berr);
  assert_word_top_reject_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'd1 && req_addr[23:0] == 24'hFFFFFF) |=> rsp_berr);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_berr));
endmodule

// File: tb/io_win_decoder_tb.sv
module io_win_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        req_super = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  mode = '0;
  logic        compat = 1'b0;
  logic        blit_off = 1'b0;
  logic        rsp_valid, rsp_berr;
  logic [31:0] rsp_rdata;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  io_win_decoder u_dut (.*);

  // {req tag 4, mode 2, compat, blit_off, super, write, size 2, addr 32, wdata 32, exp berr, exp rdata 32}
  typedef logic [108:0] vec_t;
  function automatic vec_t V(int rq, int md, bit cp, bit bo, bit sp, bit wr, int sz,
                             logic [31:0] ad, logic [31:0] wd, bit eb, logic [31:0] er);
    return {4'(rq), 2'(md), cp, bo, sp, wr, 2'(sz), ad, wd, eb, er};
  endfunction

  localparam int NV = 37;
  localparam vec_t VT [NV] = '{
    V(11,0,0,0,1,1,0,32'hFF8800,32'h12,0,32'h0),        // R11 byte write
    V(11,0,0,0,1,0,0,32'hFF8800,0,0,32'h12),            // R11 byte read
    V(6, 0,0,0,1,0,0,32'hFF8804,0,0,32'h12),            // R6 mirror
    V(11,0,0,0,1,1,1,32'hFF8802,32'hA1B2,0,32'h0),      // R11 word write
    V(11,0,0,0,1,0,2,32'hFF8800,0,0,32'h1200A1B2),      // R11 long order
    V(6, 0,0,0,1,0,1,32'hFF88FE,0,0,32'hA1B2),          // R6 mirror top
    V(2, 0,0,0,1,0,0,32'hFF8200,0,1,32'hFFFFFFFF),      // R2 hole byte
    V(3, 0,0,0,1,0,1,32'hFF8200,0,0,32'hFF00),          // R3 partial word
    V(3, 0,0,0,1,0,1,32'hFF9000,0,1,32'hFFFFFFFF),      // R3 full hole word
    V(3, 0,0,0,1,0,2,32'hFF9000,0,1,32'hFFFFFFFF),      // R3 full hole long
    V(4, 0,0,0,1,0,0,32'hFF820F,0,0,32'h0),             // R4 void zero
    V(4, 2,0,0,1,0,0,32'hFF820F,0,1,32'hFFFFFFFF),      // R4 hole outside base
    V(7, 1,0,0,1,0,0,32'hFF8200,0,0,32'hFF),            // R7 ext void
    V(7, 1,0,0,1,0,0,32'hFF8005,0,0,32'hFF),            // R7 ext void range
    V(1, 0,0,0,0,0,0,32'hFF8800,0,1,32'hFFFFFFFF),      // R1 user state
    V(1, 0,0,0,1,0,0,32'h00123456,0,1,32'hFFFFFFFF),    // R1 below window
    V(1, 0,0,0,1,0,0,32'hABFF8800,0,0,32'h12),          // R1 upper bits ignored
    V(5, 0,0,0,1,0,1,32'hFFFFFF,0,1,32'hFFFFFFFF),      // R5 word top
    V(5, 0,0,0,1,0,2,32'hFFFFFD,0,1,32'hFFFFFFFF),      // R5 long top
    V(8, 0,0,0,1,1,0,32'hFF8A10,32'h5A,0,32'h0),        // R8 blit write
    V(8, 0,0,0,1,0,0,32'hFF8A10,0,0,32'h5A),            // R8 blit read
    V(8, 0,0,1,1,0,0,32'hFF8A10,0,1,32'hFFFFFFFF),      // R8 blit off base
    V(8, 2,0,1,1,0,0,32'hFF8A10,0,0,32'h5A),            // R8 blit off other map
    V(9, 0,0,0,1,0,0,32'hFFFC21,0,0,32'hFF),            // R9 clock void
    V(9, 1,0,0,1,1,0,32'hFFFC21,32'h33,0,32'h0),        // R9 clock write
    V(4, 0,0,0,1,1,0,32'hFFFC21,32'h77,0,32'h0),        // R4 void write
    V(4, 1,0,0,1,0,0,32'hFFFC21,0,0,32'h33),            // R4 void write ignored
    V(6, 3,0,0,1,0,0,32'hFF8804,0,1,32'hFFFFFFFF),      // R6 newest no compat
    V(6, 3,1,0,1,0,0,32'hFF8804,0,0,32'hFF),            // R6 newest compat
    V(6, 3,0,0,1,0,0,32'hFF8800,0,0,32'h12),            // R6 newest direct
    V(10,0,0,0,0,1,2,32'hFF8800,32'hDEADBEEF,1,32'hFFFFFFFF), // R10 faulted write
    V(10,0,0,0,1,0,2,32'hFF8800,0,0,32'h1200A1B2),      // R10 nothing committed
    V(3, 0,0,0,1,1,1,32'hFF8200,32'h99AA,0,32'h0),      // R3 partial write
    V(3, 0,0,0,1,0,0,32'hFF8201,0,0,32'hAA),            // R3 mapped lane written
    V(5, 0,0,0,1,0,3,32'hFF8800,0,1,32'hFFFFFFFF),      // R5 bad size
    V(11,0,0,0,1,0,1,32'hFF8200,0,0,32'hFFAA),          // R11 lane mix
    V(3, 0,0,0,1,0,2,32'hFFFC3E,0,0,32'hFFFFFFFF)       // R3 void+hole long
  };

  task automatic check(int rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic access(vec_t v);
    @(negedge clk);
    req_valid = 1'b1;
    mode = v[104:103]; compat = v[102]; blit_off = v[101];
    req_super = v[100]; req_write = v[99]; req_size = v[98:97];
    req_addr = v[96:65]; req_wdata = v[64:33];
    @(negedge clk);
    req_valid = 1'b0;
    check(int'(v[108:105]), "valid", 32'(rsp_valid), 32'h1);
    check(int'(v[108:105]), "berr",  32'(rsp_berr),  32'(v[32]));
    check(int'(v[108:105]), "rdata", rsp_rdata, v[31:0]);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    check(12, "reset valid", 32'(rsp_valid), 0);
    check(12, "reset berr",  32'(rsp_berr), 0);
    check(12, "reset rdata", rsp_rdata, 0);
    for (int i = 0; i < NV; i++) access(VT[i]);
    // R10 strobe lasts one cycle after a fault
    access(V(10,0,0,0,1,0,0,32'hFF9000,0,1,32'hFFFFFFFF));
    @(negedge clk);
    check(10, "berr one cycle", 32'(rsp_berr), 0);
    check(10, "valid one cycle", 32'(rsp_valid), 0);
    // R12 reset clears registers
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    access(V(12,0,0,0,1,0,2,32'hFF8800,0,0,32'h0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule